// File: doc/BRIEF.md
# Dual-Width Integer Execution Unit

This block is the integer arithmetic and logic stage of a 64-bit virtual machine pipeline. Each request carries a 4-bit operation code, a 16-bit modifier field, a width flag and two operands. The first operand is the destination's current value. The second is either a register value or a 32-bit immediate. The block returns the value to be written back. In narrow (32-bit) mode only the low halves of the operands take part, and the upper half of the result is cleared. In wide (64-bit) mode the full operands are used.

Most operations finish one cycle after they are accepted. Divide and remainder run on an iterative divider, and `busy` stays high while it works. A request is accepted only when `in_valid` is high and `busy` is low. Each accepted request produces exactly one `out_valid` pulse, and results come out in the order the requests were accepted. The modifier field selects the signed forms of divide and remainder and the sign-extending forms of move. Any combination of code and modifier that is not defined is flagged as illegal.

Top module: `iexu_top`

## Requirements
- R1: Code 0 adds, code 1 subtracts and code 2 multiplies, and all three wrap modulo the operation width. A non-divide request raises `out_valid` for one cycle, on the clock edge after the one that accepts it. After reset, `out_valid`, `busy` and `result` are 0.
- R2: Code 4 is OR, code 5 is AND, code 10 is XOR, and code 11 with modifier 0 copies the second operand.
- R3: Code 6 shifts left and code 7 shifts right with zero fill. Code 12 shifts right and fills with the sign bit, which is bit 31 in narrow mode. The shift amount is the second operand masked with 0x3F in wide mode and 0x1F in narrow mode.
- R4: Code 8 returns the two's-complement negation of the destination operand and ignores the second operand.
- R5: When `wide`=0, only bits 31:0 of both operands are used, and bits 63:32 of every legal result are 0.
- R6: When `use_imm`=1, the 32-bit immediate is sign-extended to 64 bits and replaces the register source. This applies to unsigned divide as well.
- R7: Code 3 (divide) and code 9 (remainder) with modifier 0 are unsigned. With a nonzero divisor they raise `busy` on the edge after acceptance, and they deliver the quotient or remainder with a later `out_valid` pulse.
- R8: Modifier 1 on code 3 or code 9 selects the signed form. The quotient truncates toward zero and the remainder takes the sign of the dividend. The most negative value divided by -1 returns the most negative value, and the matching remainder is 0.
- R9: A divisor of zero (after narrowing) completes in one cycle. Divide then returns 0, and remainder returns the destination operand, narrowed in narrow mode.
- R10: Code 11 with modifier 8, 16 or 32 sign-extends the low 8, 16 or 32 bits of the second operand. Modifier 32 is legal only in wide mode.
- R11: The following are illegal: codes 13 to 15; a nonzero modifier on any code other than 3, 9 or 11; a modifier other than 0 or 1 on code 3 or 9; and a modifier other than 0, 8, 16 or 32 on code 11. An illegal request sets `out_illegal` with its single-cycle `out_valid` and returns the destination operand unchanged.
- R12: A request presented while `busy` is high is ignored: it produces no `out_valid` pulse and does not change the result in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| op_code | input | 4 | Operation code |
| op_offset | input | 16 | Modifier selecting signed or sign-extending forms |
| wide | input | 1 | 1 = 64-bit mode, 0 = 32-bit mode |
| use_imm | input | 1 | 1 = second operand is the immediate |
| dst_val | input | 64 | Destination operand |
| src_val | input | 64 | Register source operand |
| imm_val | input | 32 | Immediate source operand |
| busy | output | 1 | Divider occupied; requests are ignored |
| out_valid | output | 1 | Result present for one cycle |
| out_illegal | output | 1 | Request encoding was illegal |
| result | output | 64 | New destination value |

## Verification
The divider's iteration counter and its sign flags are the only internal state that lasts across cycles. A counter that is off by one moves the `out_valid` pulse and shifts the quotient by one bit, so the very first divide shows a wrong value at the port. A lost sign flag shows up on the first signed divide that has mixed operand signs. The wrong-sign result appears on the first `out_valid` pulse of that divide, 65 cycles after acceptance. A busy flag that stays stuck either drops later requests or produces an extra result pulse, and the scoreboard sees that as a missing or an unexpected item on the next request.

// File: rtl/iexu_pkg.sv
package iexu_pkg;

   typedef enum logic [3:0] {
      OP_ADD  = 4'h0,
      OP_SUB  = 4'h1,
      OP_MUL  = 4'h2,
      OP_DIV  = 4'h3,
      OP_OR   = 4'h4,
      OP_AND  = 4'h5,
      OP_LSH  = 4'h6,
      OP_RSH  = 4'h7,
      OP_NEG  = 4'h8,
      OP_MOD  = 4'h9,
      OP_XOR  = 4'ha,
      OP_MOV  = 4'hb,
      OP_ARSH = 4'hc
   } alu_op_e;

   localparam logic [15:0] MOD_PLAIN  = 16'd0;
   localparam logic [15:0] MOD_SIGNED = 16'd1;
   localparam logic [15:0] MOD_SX8    = 16'd8;
   localparam logic [15:0] MOD_SX16   = 16'd16;
   localparam logic [15:0] MOD_SX32   = 16'd32;

endpackage

// File: rtl/iexu_operand.sv
module iexu_operand #(
   parameter int DATA_W = 64,
   parameter int IMM_W  = 32
) (
   input  logic              wide,
   input  logic              use_imm,
   input  logic [DATA_W-1:0] dst_val,
   input  logic [DATA_W-1:0] src_val,
   input  logic [IMM_W-1:0]  imm_val,
   output logic [DATA_W-1:0] opa,
   output logic [DATA_W-1:0] opb
);
   localparam int HALF_W = DATA_W / 2;

   logic [DATA_W-1:0] imm_ext;
   logic [DATA_W-1:0] src_sel;

   always_comb begin
      imm_ext = {{(DATA_W-IMM_W){imm_val[IMM_W-1]}}, imm_val};
      src_sel = use_imm ? imm_ext : src_val;
      opa     = wide ? dst_val : {{HALF_W{1'b0}}, dst_val[HALF_W-1:0]};
      opb     = wide ? src_sel : {{HALF_W{1'b0}}, src_sel[HALF_W-1:0]};
   end
endmodule

// File: rtl/iexu_simple.sv
module iexu_simple
   import iexu_pkg::*;
#(
   parameter int DATA_W = 64
) (
   input  logic [3:0]        op_code,
   input  logic [15:0]       op_offset,
   input  logic              wide,
   input  logic [DATA_W-1:0] dst_val,
   input  logic [DATA_W-1:0] opa,
   input  logic [DATA_W-1:0] opb,
   output logic [DATA_W-1:0] res,
   output logic              illegal,
   output logic              needs_div
);
   localparam int HALF_W = DATA_W / 2;
   localparam int SH_W   = $clog2(DATA_W);

   alu_op_e                  op;
   logic                     legal;
   logic [SH_W-1:0]          sh;
   logic signed [DATA_W-1:0] ars_s;
   logic [DATA_W-1:0]        raw;

   always_comb begin
      op = alu_op_e'(op_code);
      case (op_code)
         OP_DIV, OP_MOD: legal = (op_offset == MOD_PLAIN) || (op_offset == MOD_SIGNED);
         OP_MOV:         legal = (op_offset == MOD_PLAIN) || (op_offset == MOD_SX8) ||
                                 (op_offset == MOD_SX16) || (wide && op_offset == MOD_SX32);
         4'hd, 4'he, 4'hf: legal = 1'b0;
         default:        legal = (op_offset == MOD_PLAIN);
      endcase
      illegal   = !legal;
      needs_div = legal && (op == OP_DIV || op == OP_MOD) && (opb != '0);

      sh    = wide ? opb[SH_W-1:0] : {1'b0, opb[SH_W-2:0]};
      ars_s = wide ? opa : {{HALF_W{opa[HALF_W-1]}}, opa[HALF_W-1:0]};

      unique case (op)
         OP_ADD:  raw = opa + opb;
         OP_SUB:  raw = opa - opb;
         OP_MUL:  raw = opa * opb;
         OP_OR:   raw = opa | opb;
         OP_AND:  raw = opa & opb;
         OP_XOR:  raw = opa ^ opb;
         OP_LSH:  raw = opa << sh;
         OP_RSH:  raw = opa >> sh;
         OP_ARSH: raw = ars_s >>> sh;
         OP_NEG:  raw = '0 - opa;
         OP_DIV:  raw = '0;
         OP_MOD:  raw = opa;
         OP_MOV: begin
            if (op_offset == MOD_SX8)       raw = {{(DATA_W-8){opb[7]}}, opb[7:0]};
            else if (op_offset == MOD_SX16) raw = {{(DATA_W-16){opb[15]}}, opb[15:0]};
            else if (op_offset == MOD_SX32) raw = {{(DATA_W-32){opb[31]}}, opb[31:0]};
            else                            raw = opb;
         end
         default: raw = dst_val;
      endcase

      if (illegal)   res = dst_val;
      else if (wide) res = raw;
      else           res = {{HALF_W{1'b0}}, raw[HALF_W-1:0]};
   end
endmodule

// File: rtl/iexu_divider.sv
module iexu_divider #(
   parameter int DATA_W    = 64,
   parameter int DIV_STEPS = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              signed_op,
   input  logic [DATA_W-1:0] num,
   input  logic [DATA_W-1:0] den,
   output logic              done,
   output logic [DATA_W-1:0] quo,
   output logic [DATA_W-1:0] rem
);
   localparam int ITER = DATA_W / DIV_STEPS;
   localparam int CW   = $clog2(ITER + 1);

   logic [CW-1:0]     cnt_q;
   logic              done_q, neg_n_q, neg_d_q;
   logic [DATA_W-1:0] r_q, q_q, d_q;
   logic              neg_n, neg_d;
   logic [DATA_W-1:0] r_ch [DIV_STEPS+1];
   logic [DATA_W-1:0] q_ch [DIV_STEPS+1];

   assign neg_n   = signed_op & num[DATA_W-1];
   assign neg_d   = signed_op & den[DATA_W-1];
   assign r_ch[0] = r_q;
   assign q_ch[0] = q_q;

   for (genvar gi = 0; gi < DIV_STEPS; gi++) begin : g_step
      logic [DATA_W:0] shifted;
      logic [DATA_W:0] diff;
      assign shifted      = {r_ch[gi], q_ch[gi][DATA_W-1]};
      assign diff         = shifted - {1'b0, d_q};
      assign r_ch[gi+1]   = diff[DATA_W] ? shifted[DATA_W-1:0] : diff[DATA_W-1:0];
      assign q_ch[gi+1]   = {q_ch[gi][DATA_W-2:0], ~diff[DATA_W]};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         done_q  <= 1'b0;
         neg_n_q <= 1'b0;
         neg_d_q <= 1'b0;
         r_q     <= '0;
         q_q     <= '0;
         d_q     <= '0;
      end else begin
         done_q <= 1'b0;
         if (start) begin
            cnt_q   <= CW'(ITER);
            neg_n_q <= neg_n;
            neg_d_q <= neg_d;
            r_q     <= '0;
            q_q     <= neg_n ? (~num + 1'b1) : num;
            d_q     <= neg_d ? (~den + 1'b1) : den;
         end else if (cnt_q != '0) begin
            cnt_q  <= cnt_q - 1'b1;
            r_q    <= r_ch[DIV_STEPS];
            q_q    <= q_ch[DIV_STEPS];
            done_q <= (cnt_q == CW'(1));
         end
      end
   end

   assign done = done_q;
   assign quo  = (neg_n_q ^ neg_d_q) ? (~q_q + 1'b1) : q_q;
   assign rem  = neg_n_q ? (~r_q + 1'b1) : r_q;

   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CW'(ITER)); // R7
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q); // R7
   AST_DONE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> cnt_q == '0); // R7
endmodule

// File: rtl/iexu_top.sv
module iexu_top
   import iexu_pkg::*;
#(
   parameter int DATA_W    = 64,
   parameter int IMM_W     = 32,
   parameter int DIV_STEPS = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [3:0]        op_code,
   input  logic [15:0]       op_offset,
   input  logic              wide,
   input  logic              use_imm,
   input  logic [DATA_W-1:0] dst_val,
   input  logic [DATA_W-1:0] src_val,
   input  logic [IMM_W-1:0]  imm_val,
   output logic              busy,
   output logic              out_valid,
   output logic              out_illegal,
   output logic [DATA_W-1:0] result
);
   localparam int HALF_W = DATA_W / 2;

   if (DATA_W < 2 * IMM_W || DATA_W % 2 != 0) begin : g_bad_width
      $error("iexu_top: DATA_W must be even and at least twice IMM_W");
   end
   if (DIV_STEPS < 1 || DATA_W % DIV_STEPS != 0) begin : g_bad_steps
      $error("iexu_top: DIV_STEPS must divide DATA_W");
   end

   logic [DATA_W-1:0] opa, opb, s_res, num, den, d_quo, d_rem, d_val;
   logic              s_ill, needs_div, accept, start, sgn, d_done;
   logic              busy_q, vld_q, ill_q, mod_q, narrow_q;
   logic [DATA_W-1:0] res_q;

   iexu_operand #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_opnd (
      .wide(wide), .use_imm(use_imm), .dst_val(dst_val), .src_val(src_val),
      .imm_val(imm_val), .opa(opa), .opb(opb));

   iexu_simple #(.DATA_W(DATA_W)) u_simple (
      .op_code(op_code), .op_offset(op_offset), .wide(wide), .dst_val(dst_val),
      .opa(opa), .opb(opb), .res(s_res), .illegal(s_ill), .needs_div(needs_div));

   assign accept = in_valid && !busy_q;
   assign start  = accept && needs_div;
   assign sgn    = (op_offset == MOD_SIGNED);
   assign num    = (sgn && !wide) ? {{HALF_W{opa[HALF_W-1]}}, opa[HALF_W-1:0]} : opa;
   assign den    = (sgn && !wide) ? {{HALF_W{opb[HALF_W-1]}}, opb[HALF_W-1:0]} : opb;

   iexu_divider #(.DATA_W(DATA_W), .DIV_STEPS(DIV_STEPS)) u_div (
      .clk(clk), .rst_n(rst_n), .start(start), .signed_op(sgn), .num(num), .den(den),
      .done(d_done), .quo(d_quo), .rem(d_rem));

   assign d_val = mod_q ? d_rem : d_quo;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q   <= 1'b0;
         vld_q    <= 1'b0;
         ill_q    <= 1'b0;
         mod_q    <= 1'b0;
         narrow_q <= 1'b0;
         res_q    <= '0;
      end else begin
         vld_q <= 1'b0;
         if (accept) begin
            narrow_q <= !wide;
            if (needs_div) begin
               busy_q <= 1'b1;
               mod_q  <= (op_code == OP_MOD);
            end else begin
               vld_q <= 1'b1;
               ill_q <= s_ill;
               res_q <= s_res;
            end
         end else if (busy_q && d_done) begin
            busy_q <= 1'b0;
            vld_q  <= 1'b1;
            ill_q  <= 1'b0;
            res_q  <= narrow_q ? {{HALF_W{1'b0}}, d_val[HALF_W-1:0]} : d_val;
         end
      end
   end

   assign busy        = busy_q;
   assign out_valid   = vld_q;
   assign out_illegal = ill_q;
   assign result      = res_q;

   AST_FAST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && !busy && !needs_div |=> out_valid); // R1
   AST_NARROW_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_illegal && narrow_q |-> result[DATA_W-1:HALF_W] == '0); // R5
   AST_DIV_GOES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && !busy && needs_div |=> busy && !out_valid); // R7
   AST_BUSY_NO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !d_done |=> !out_valid); // R12
endmodule

// File: tb/iexu_top_tb.sv
module iexu_top_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [3:0]  op_code = '0;
   logic [15:0] op_offset = '0;
   logic        wide = 1'b0;
   logic        use_imm = 1'b0;
   logic [63:0] dst_val = '0;
   logic [63:0] src_val = '0;
   logic [31:0] imm_val = '0;
   logic        busy, out_valid, out_illegal;
   logic [63:0] result;

   int compared = 0;
   int mismatched = 0;

   typedef struct {
      logic [63:0] res;
      bit          ill;
      string       tag;
   } exp_t;
   exp_t sb_q[$];

   always #10 clk = ~clk;

   iexu_top u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_code(op_code),
      .op_offset(op_offset), .wide(wide), .use_imm(use_imm), .dst_val(dst_val),
      .src_val(src_val), .imm_val(imm_val), .busy(busy), .out_valid(out_valid),
      .out_illegal(out_illegal), .result(result));

   function automatic void model(input logic [3:0] op, input logic [15:0] off, input bit w,
                                 input bit ui, input logic [63:0] d, input logic [63:0] s,
                                 input logic [31:0] im, output logic [63:0] r, output bit ill);
      logic [63:0] sx, a, b;
      logic [5:0]  sh;
      logic [31:0] t32;
      longint      la, lb;
      int          ia, ib;
      sx = ui ? {{32{im[31]}}, im} : s;
      a  = w ? d : {32'b0, d[31:0]};
      b  = w ? sx : {32'b0, sx[31:0]};
      sh = w ? b[5:0] : {1'b0, b[4:0]};
      case (op)
         4'h3, 4'h9: ill = !(off == 0 || off == 1);
         4'hb:       ill = !(off == 0 || off == 8 || off == 16 || (w && off == 32));
         4'hd, 4'he, 4'hf: ill = 1;
         default:    ill = (off != 0);
      endcase
      if (ill) begin
         r = d;
         return;
      end
      case (op)
         4'h0: r = a + b;
         4'h1: r = a - b;
         4'h2: r = a * b;
         4'h4: r = a | b;
         4'h5: r = a & b;
         4'ha: r = a ^ b;
         4'h6: r = a << sh;
         4'h7: r = a >> sh;
         4'hc: begin
            if (w) r = $signed(a) >>> sh;
            else begin
               t32 = $signed(a[31:0]) >>> sh;
               r = {32'b0, t32};
            end
         end
         4'h8: r = 64'd0 - a;
         4'hb: begin
            if (off == 8)       r = {{56{b[7]}}, b[7:0]};
            else if (off == 16) r = {{48{b[15]}}, b[15:0]};
            else if (off == 32) r = {{32{b[31]}}, b[31:0]};
            else                r = b;
         end
         default: begin
            if (b == 0) r = (op == 4'h3) ? 64'd0 : a;
            else if (off == 0) r = (op == 4'h3) ? a / b : a % b;
            else if (w) begin
               la = a; lb = b;
               if (la == 64'sh8000000000000000 && lb == -1) r = (op == 4'h3) ? a : 64'd0;
               else r = (op == 4'h3) ? la / lb : la % lb;
            end else begin
               ia = a[31:0]; ib = b[31:0];
               if (ia == 32'sh80000000 && ib == -1) r = (op == 4'h3) ? {32'b0, a[31:0]} : 64'd0;
               else begin
                  t32 = (op == 4'h3) ? ia / ib : ia % ib;
                  r = {32'b0, t32};
               end
            end
         end
      endcase
      if (!w) r = {32'b0, r[31:0]};
   endfunction

   task automatic send(input string tag, input logic [3:0] op, input logic [15:0] off,
                       input bit w, input bit ui, input logic [63:0] d, input logic [63:0] s,
                       input logic [31:0] im);
      exp_t e;
      while (busy) @(negedge clk);
      model(op, off, w, ui, d, s, im, e.res, e.ill);
      e.tag = tag;
      sb_q.push_back(e);
      op_code = op; op_offset = off; wide = w; use_imm = ui;
      dst_val = d; src_val = s; imm_val = im; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         compared++;
         if (sb_q.size() == 0) begin
            mismatched++;
            $display("FAIL R12 unexpected result: actual %h, expected no out_valid", result);
         end else begin
            exp_t e;
            e = sb_q.pop_front();
            if (result !== e.res || out_illegal !== e.ill) begin
               mismatched++;
               $display("FAIL %s: actual %h ill=%0b, expected %h ill=%0b",
                        e.tag, result, out_illegal, e.res, e.ill);
            end
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      mismatched++;
      $display("FAIL R7 watchdog: actual run still active, expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      compared++;
      if (out_valid !== 1'b0 || busy !== 1'b0 || result !== 64'd0) begin
         mismatched++;
         $display("FAIL R1 reset: actual v=%0b b=%0b r=%h, expected 0 0 0", out_valid, busy, result);
      end

      send("R1 add wrap",   4'h0, 0, 1, 0, 64'hffff_ffff_ffff_ffff, 64'd1, 0);
      send("R1 sub narrow", 4'h1, 0, 0, 0, 64'h1234_0000_0000_0000, 64'd1, 0);
      send("R1 mul wide",   4'h2, 0, 1, 0, 64'h0000_0001_0000_0003, 64'h0000_0002_0000_0005, 0);
      send("R2 or imm",     4'h4, 0, 1, 1, 64'h10, 0, 32'h8000_0001);
      send("R2 and",        4'h5, 0, 1, 0, 64'hff00_ff00_ff00_ff00, 64'h0ff0_0ff0_0ff0_0ff0, 0);
      send("R2 xor",        4'ha, 0, 0, 0, 64'hdead_beef_1111_2222, 64'h5555_5555_ffff_ffff, 0);
      send("R2 mov",        4'hb, 0, 1, 0, 0, 64'hcafe_f00d_1234_5678, 0);
      send("R3 lsh mask64", 4'h6, 0, 1, 0, 64'h3, 64'd65, 0);
      send("R3 lsh mask32", 4'h6, 0, 0, 0, 64'h3, 64'd33, 0);
      send("R3 rsh",        4'h7, 0, 1, 0, 64'h8000_0000_0000_0000, 64'd4, 0);
      send("R3 arsh wide",  4'hc, 0, 1, 0, 64'h8000_0000_0000_0000, 64'd4, 0);
      send("R3 arsh narrow",4'hc, 0, 0, 1, 64'h0000_0000_8000_0000, 0, 32'd36);
      send("R4 neg",        4'h8, 0, 1, 0, 64'd5, 64'hffff, 0);
      send("R5 narrow add", 4'h0, 0, 0, 0, 64'hffff_ffff_ffff_ffff, 64'hffff_ffff_0000_0001, 0);
      send("R6 imm add",    4'h0, 0, 1, 1, 64'd10, 0, 32'hffff_fffe);
      send("R6 udiv imm",   4'h3, 0, 1, 1, 64'd1000, 0, 32'hffff_ffff);
      send("R7 udiv",       4'h3, 0, 1, 0, 64'd1000, 64'd7, 0);
      send("R7 umod",       4'h9, 0, 0, 0, 64'hffff_0000_0000_03e8, 64'd7, 0);
      send("R8 sdiv",       4'h3, 1, 1, 0, -64'sd100, 64'd7, 0);
      send("R8 smod",       4'h9, 1, 1, 0, -64'sd100, 64'd7, 0);
      send("R8 smod neg d", 4'h9, 1, 0, 1, 64'd100, 0, -32'sd7);
      send("R8 min/-1",     4'h3, 1, 1, 0, 64'h8000_0000_0000_0000, -64'sd1, 0);
      send("R8 min%-1",     4'h9, 1, 1, 0, 64'h8000_0000_0000_0000, -64'sd1, 0);
      send("R8 min32/-1",   4'h3, 1, 0, 1, 64'h0000_0000_8000_0000, 0, 32'hffff_ffff);
      send("R9 div zero",   4'h3, 0, 1, 0, 64'd77, 0, 0);
      send("R9 mod zero",   4'h9, 1, 0, 0, 64'hffff_ffff_0000_0042, 64'hffff_ffff_0000_0000, 0);
      send("R10 sx8",       4'hb, 8, 1, 0, 0, 64'h80, 0);
      send("R10 sx16 nar",  4'hb, 16, 0, 0, 0, 64'h8001, 0);
      send("R10 sx32",      4'hb, 32, 1, 1, 0, 0, 32'h8000_0000);
      send("R10 sx32 nar",  4'hb, 32, 0, 0, 64'h1234, 64'h5, 0);
      send("R11 code d",    4'hd, 0, 1, 0, 64'habcd, 64'h1, 0);
      send("R11 add off",   4'h0, 1, 1, 0, 64'hffff_0000_1111_2222, 64'h1, 0);
      send("R11 div off2",  4'h3, 2, 1, 0, 64'h99, 64'h3, 0);

      send("R12 div",       4'h3, 0, 1, 0, 64'd100, 64'd7, 0);
      op_code = 4'h0; op_offset = 0; wide = 1; use_imm = 0;
      dst_val = 64'd1; src_val = 64'd2; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;

      for (int i = 0; i < 40; i++) begin
         logic [3:0]  op;
         logic [15:0] off;
         op  = 4'($urandom_range(0, 12));
         off = 0;
         if ((op == 4'h3 || op == 4'h9) && $urandom_range(0, 1) == 1) off = 1;
         send("R1 R8 mix", op, off, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
              {$urandom, $urandom}, {$urandom, $urandom}, $urandom);
      end

      for (int i = 0; i < 400 && sb_q.size() != 0; i++) @(negedge clk);
      repeat (5) @(negedge clk);
      compared++;
      if (sb_q.size() != 0) begin
         mismatched++;
         $display("FAIL R7 missing results: actual %0d pending, expected 0", sb_q.size());
      end
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule